// File: doc/BRIEF.md
# Gated 22 kHz Tone Keyer

This block derives a square-wave carrier of nominally 22 kHz from the system clock and gates it onto a single tone output. The tone path is live only while the main enable is high and at least one of two path-enable sources is high: a register bit and an external pin. With the path live, the tone either runs without a break (continuous mode) or is keyed by an asynchronous data-envelope input. A pull-down strobe is high for as long as a burst is in progress, so that external circuitry can discharge the load only while the carrier is being driven.

A keyed burst starts half a carrier cycle after the synchronized envelope is accepted. It ends on the second half-cycle boundary after the envelope is seen low, which is close to one full carrier cycle. The output always idles low. The half-cycle length is `HALF_CYC = CLK_HZ / (2*TONE_HZ)` clocks. The divider is cleared whenever the block is idle, so every burst begins in the same phase.

The controller has four states. IDLE has no tone and the divider held at zero. ARM waits out the start delay. RUN toggles the carrier. TAIL lets the carrier finish after the key drops. The transitions are:
- IDLE→RUN on continuous request.
- IDLE→ARM on envelope.
- ARM→RUN on the timer wrap or on continuous request.
- ARM→IDLE on envelope loss or path loss.
- RUN→TAIL on key loss.
- TAIL→RUN on key return.
- TAIL→IDLE on the second boundary.
- RUN/TAIL→IDLE on path loss.

Top module: `tone_gen22`

## Requirements
- R1: While `rst_n` is low, `tone_out` and `pd_ctl` are 0.
- R2: With `main_en`=0, or with both `ttx_reg` and `ttx_pin` at 0, no burst starts; `tone_out` and `pd_ctl` stay 0 whatever `cont_en` and `env_in` do. Either path-enable source alone is enough to open the path.
- R3: With the path open and `cont_en`=1, a burst that is not already running starts on the next clock edge, with `tone_out`=1 and `pd_ctl`=1.
- R4: With the path open and `cont_en`=0, `tone_out` first goes high on the (3+HALF_CYC)-th rising clock edge after `env_in` goes high. Of these edges, two are for the synchronizer, one is for acceptance and HALF_CYC are for the delay.
- R5: During a burst the carrier starts high, and each high and each low level lasts exactly HALF_CYC clocks (50% duty).
- R6: After the key goes away (`cont_en`=0 and the synchronized envelope low), the carrier keeps toggling and the burst ends at the second half-cycle boundary. `pd_ctl` falls between HALF_CYC+4 and 2*HALF_CYC+3 edges after `env_in` falls, and `tone_out` is then 0.
- R7: An envelope pulse that ends before the start delay has elapsed produces no tone and no `pd_ctl` pulse.
- R8: When the path closes (main enable or both path enables drop), `tone_out` and `pd_ctl` are 0 after the next clock edge.
- R9: `pd_ctl` is 1 exactly while a burst (RUN or TAIL) is in progress, and `tone_out` is never 1 while `pd_ctl` is 0.
- R10: If the key returns during the tail, the burst continues without a gap and without a phase break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_en | input | 1 | Main enable; 0 forces the tone off |
| ttx_reg | input | 1 | Tone-path enable from a control register bit |
| ttx_pin | input | 1 | Tone-path enable from an external pin |
| cont_en | input | 1 | Continuous-tone request |
| env_in | input | 1 | Asynchronous data-envelope input that keys the tone |
| tone_out | output | 1 | Carrier output, idles low |
| pd_ctl | output | 1 | Pull-down strobe, high while a burst runs |

## Verification
The carrier is tried in four ways. Continuous mode separates duty and period errors from keying errors. Long envelope pulses expose the start and stop delays. Pulses shorter than the start delay confirm that they are suppressed. Envelope gaps shorter than the tail confirm that a burst resumes seamlessly. Path-enable patterns (only the register bit, only the pin, neither, main enable dropped mid-burst) separate the gating logic from the timing logic. A behavioural model predicts both outputs on every clock, and directed measurements pin the exact start delay, the window for the stop delay and the level lengths.

// File: rtl/tone_pkg.sv
package tone_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_TAIL = 2'd3
    } tone_state_t;

    localparam int unsigned TAIL_HALVES = 2;
endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/tone_halfcnt.sv
module tone_halfcnt #(
    parameter int unsigned HALF_CYC = 1136
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (run)   cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/tone_gen22.sv
module tone_gen22 #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned TONE_HZ     = 22_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_en,
    input  logic ttx_reg,
    input  logic ttx_pin,
    input  logic cont_en,
    input  logic env_in,
    output logic tone_out,
    output logic pd_ctl
);
    import tone_pkg::*;

    localparam int unsigned HALF_CYC = CLK_HZ / (2 * TONE_HZ);
    localparam int unsigned HW       = $clog2(TAIL_HALVES + 1);

    tone_state_t   state_q, state_nx;
    logic          phase_q, phase_nx;
    logic [HW-1:0] halves_q, halves_nx;
    logic          restart;
    logic          env_s;
    logic          tick;
    logic          path_on;
    logic          key_on;

    tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (env_in),
        .sync_out (env_s)
    );

    tone_halfcnt #(.HALF_CYC(HALF_CYC)) u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state_q == ST_IDLE) || restart),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    assign path_on = main_en && (ttx_reg || ttx_pin);
    assign key_on  = cont_en || env_s;

    // next-state and datapath decisions
    always_comb begin
        state_nx  = state_q;
        phase_nx  = phase_q;
        halves_nx = halves_q;
        restart   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                phase_nx = 1'b0;
                if (path_on && cont_en) begin
                    state_nx = ST_RUN;
                    phase_nx = 1'b1;
                    restart  = 1'b1;
                end else if (path_on && env_s) begin
                    state_nx = ST_ARM;
                end
            end
            ST_ARM: begin
                if (!path_on) begin
                    state_nx = ST_IDLE;
                end else if (cont_en) begin
                    state_nx = ST_RUN;
                    phase_nx = 1'b1;
                    restart  = 1'b1;
                end else if (!env_s) begin
                    state_nx = ST_IDLE;
                end else if (tick) begin
                    state_nx = ST_RUN;
                    phase_nx = 1'b1;
                end
            end
            ST_RUN: begin
                if (!path_on) begin
                    state_nx = ST_IDLE;
                    phase_nx = 1'b0;
                end else begin
                    if (tick) phase_nx = ~phase_q;
                    if (!key_on) begin
                        state_nx  = ST_TAIL;
                        halves_nx = HW'(TAIL_HALVES);
                    end
                end
            end
            ST_TAIL: begin
                if (!path_on) begin
                    state_nx = ST_IDLE;
                    phase_nx = 1'b0;
                end else if (key_on) begin
                    state_nx = ST_RUN;
                    if (tick) phase_nx = ~phase_q;
                end else if (tick) begin
                    if (halves_q == HW'(1)) begin
                        state_nx = ST_IDLE;
                        phase_nx = 1'b0;
                    end else begin
                        halves_nx = halves_q - 1'b1;
                        phase_nx  = ~phase_q;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // carrier phase and tail bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= 1'b0;
            halves_q <= '0;
        end else begin
            phase_q  <= phase_nx;
            halves_q <= halves_nx;
        end
    end

    // outputs
    always_comb begin
        pd_ctl   = 1'b0;
        tone_out = 1'b0;
        unique case (state_q)
            ST_RUN, ST_TAIL: begin
                pd_ctl   = 1'b1;
                tone_out = phase_q;
            end
            default: begin
                pd_ctl   = 1'b0;
                tone_out = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tone_gen22_chk.sv
module tone_gen22_chk (
    input logic clk,
    input logic rst_n,
    input logic main_en,
    input logic ttx_reg,
    input logic ttx_pin,
    input logic cont_en,
    input logic env_in,
    input logic tone_out,
    input logic pd_ctl
);
    // R1
    r1_reset_chk: assert property (@(posedge clk)
        !rst_n |-> (!tone_out && !pd_ctl));

    // R2
    r2_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_ctl && !(main_en && (ttx_reg || ttx_pin))) |=> !pd_ctl);

    // R3
    r3_cont_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_ctl && main_en && (ttx_reg || ttx_pin) && cont_en) |=> (pd_ctl && tone_out));

    // R8
    r8_force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_en && (ttx_reg || ttx_pin)) |=> (!pd_ctl && !tone_out));

    // R9
    r9_tone_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tone_out |-> pd_ctl);
endmodule

bind tone_gen22 tone_gen22_chk u_chk (.*);

// File: tb/test_tone_gen22.sv
module test_tone_gen22;
    localparam int unsigned CLK_HZ  = 440_000;
    localparam int unsigned TONE_HZ = 22_000;
    localparam int H = CLK_HZ / (2 * TONE_HZ);

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic main_en = 1'b0, ttx_reg = 1'b0, ttx_pin = 1'b0, cont_en = 1'b0, env_in = 1'b0;
    logic tone_out, pd_ctl;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    tone_gen22 #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) i_tone_gen22 (
        .clk(clk), .rst_n(rst_n), .main_en(main_en), .ttx_reg(ttx_reg),
        .ttx_pin(ttx_pin), .cont_en(cont_en), .env_in(env_in),
        .tone_out(tone_out), .pd_ctl(pd_ctl)
    );

    // behavioural reference: 0 quiet, 1 waiting, 2 sounding, 3 finishing
    int  m_mode = 0, m_cnt = 0, m_left = 0;
    bit  m_hi = 0;
    bit  env_p[$] = '{0, 0};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_left = 0; m_hi = 0;
            env_p = '{0, 0};
        end else begin
            bit path, key, wrap, es;
            int nm, nc;
            es   = env_p[1];
            path = main_en && (ttx_reg || ttx_pin);
            key  = cont_en || es;
            wrap = (m_mode != 0) && (m_cnt == H - 1);
            nm = m_mode;
            nc = (m_mode == 0) ? 0 : (wrap ? 0 : m_cnt + 1);
            case (m_mode)
                0: if (path && cont_en) begin nm = 2; m_hi = 1; nc = 0; end
                   else if (path && es) nm = 1;
                1: if (!path) nm = 0;
                   else if (cont_en) begin nm = 2; m_hi = 1; nc = 0; end
                   else if (!es) nm = 0;
                   else if (wrap) begin nm = 2; m_hi = 1; end
                2: if (!path) begin nm = 0; m_hi = 0; end
                   else begin
                       if (wrap) m_hi = !m_hi;
                       if (!key) begin nm = 3; m_left = 2; end
                   end
                default: if (!path) begin nm = 0; m_hi = 0; end
                   else if (key) begin nm = 2; if (wrap) m_hi = !m_hi; end
                   else if (wrap) begin
                       if (m_left == 1) begin nm = 0; m_hi = 0; end
                       else begin m_left--; m_hi = !m_hi; end
                   end
            endcase
            m_mode = nm; m_cnt = nc;
            void'(env_p.pop_back());
            env_p.push_front(env_in);
        end
    end

    task automatic note(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the model (R5 R6 R9 R10 timing)
    always @(negedge clk) begin
        if (rst_n) begin
            bit et, ep;
            ep = (m_mode >= 2);
            et = ep && m_hi;
            note(tone_out === et, "R5 model tone_out", tone_out, et);
            note(pd_ctl === ep, "R9 model pd_ctl", pd_ctl, ep);
        end
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    int k, hi_len, lo_len;
    bit seen;

    initial begin
        #1 rst_n = 1'b0;
        step(3);
        // R1
        note(!tone_out && !pd_ctl, "R1 reset outputs", {tone_out, pd_ctl}, 0);
        rst_n = 1'b1;
        step(2);

        // R2: path closed, cont and envelope ignored
        cont_en = 1; env_in = 1; main_en = 1;
        step(4 * H);
        note(!pd_ctl && !tone_out, "R2 ttx both low", pd_ctl, 0);
        ttx_reg = 1; main_en = 0;
        step(4 * H);
        note(!pd_ctl, "R2 main_en low", pd_ctl, 0);
        cont_en = 0; env_in = 0; ttx_reg = 0;
        step(5);

        // R3 and R5: continuous via pin-only path
        main_en = 1; ttx_pin = 1; cont_en = 1;
        step(1);
        note(pd_ctl && tone_out, "R3 cont start", {pd_ctl, tone_out}, 3);
        hi_len = 0; lo_len = 0;
        while (tone_out) begin hi_len++; step(1); end
        while (!tone_out) begin lo_len++; step(1); end
        note(hi_len == H, "R5 high length", hi_len, H);
        note(lo_len == H, "R5 low length", lo_len, H);
        step(3 * H + 3);

        // R8: path drop forces off on next edge
        ttx_pin = 0;
        step(1);
        note(!pd_ctl && !tone_out, "R8 forced off", pd_ctl, 0);
        cont_en = 0;
        step(5);

        // R4: keyed start via register-only path
        ttx_reg = 1; env_in = 1;
        k = 0;
        while (!tone_out && k < 10 * H) begin step(1); k++; end
        note(k == 3 + H, "R4 start delay", k, 3 + H);
        step(5 * H + 2);

        // R6: stop window
        env_in = 0;
        k = 0;
        while (pd_ctl && k < 10 * H) begin step(1); k++; end
        note(k >= H + 4 && k <= 2 * H + 3, "R6 stop delay", k, H + 4);
        note(!tone_out, "R6 ends low", tone_out, 0);
        step(3);

        // R7: short envelope pulse
        env_in = 1; step(H / 2); env_in = 0;
        seen = 0;
        for (int i = 0; i < 3 * H; i++) begin step(1); if (pd_ctl || tone_out) seen = 1; end
        note(!seen, "R7 short pulse", seen, 0);

        // R10: gap shorter than the tail
        env_in = 1; step(6 * H);
        env_in = 0; step(2); env_in = 1;
        seen = 0;
        for (int i = 0; i < 4 * H; i++) begin step(1); if (!pd_ctl) seen = 1; end
        note(!seen, "R10 no gap", seen, 0);
        env_in = 0;
        step(4 * H);
        note(!pd_ctl, "R6 final idle", pd_ctl, 0);

        // R8 during keyed burst
        env_in = 1; step(6 * H);
        main_en = 0; step(1);
        note(!pd_ctl && !tone_out, "R8 main drop", pd_ctl, 0);
        env_in = 0; main_en = 1; step(6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule